// File: doc/BRIEF.md
# Selectable-Rate CIC Interpolator

This block raises the sample rate of a pair of baseband streams, the in-phase (I) and quadrature (Q) channels, by a factor of 3 or 4. A cascaded integrator-comb structure does the work. Three comb stages run at the low input rate. Between the comb and integrator sections the low-rate samples are zero-stuffed to the high rate. Three integrator stages then run at the system clock rate. The cascade has a built-in low-pass response, so it suppresses the spectral images that upsampling creates. One output sample per channel leaves the block on every clock cycle.

The factor is chosen at run time by a single select input. Changing it clears all filter state. The raw filter gain is R squared, that is 9 or 16, and it depends on the factor. A scaling stage built from a constant multiply, a rounding offset and a shift removes this gain, so a constant input gives the same output level at either rate. Internal registers are sized for the worst-case gain of factor 4.

An internal phase counter defines input slots, one every R clocks. An upstream source places one sample in each slot. A slot without a valid sample counts as a zero sample.

Top module: `cic_interp_iq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the state is cleared and both outputs read 0 after that edge. The first rising edge with `rst_n` high is an input slot.
- R2: Input slots recur every R rising edges. R is 3 when `rate_sel` = 0 and 4 when `rate_sel` = 1. A sample is taken at a slot edge when `in_valid` is high there.
- R3: Before scaling, each channel's output equals the zero-stuffed input sequence convolved with the threefold self-convolution of an all-ones window of length R. The first term of that convolution appears on the output after the 4th rising edge that follows the capture edge.
- R4: The output is floor((acc*K + 2048) / 4096), truncated to 12 bits, where acc is the value from R3. K is 256 for R = 4 and 455 for R = 3.
- R5: A constant input x with -2047 <= x <= 2047 settles to an output of exactly x at both rates.
- R6: The I and Q channels are filtered identically and independently. The data on one channel has no effect on the other.
- R7: At a slot edge with `in_valid` low, the sample is taken as zero. `in_valid` and the data inputs at non-slot edges are ignored.
- R8: At a rising edge where `rate_sel` differs from the active rate, all filter state and both outputs are cleared, and the new rate becomes active. Any sample at that edge is discarded, and the next edge is a slot.
- R9: Full-scale constant inputs do not wrap at rate 4: +2047 gives 2047 and -2048 gives -2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, high-rate domain |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 1 | Factor select: 0 gives 3, 1 gives 4 |
| in_valid | input | 1 | Sample present in the current slot |
| in_i | input | 12 | Signed I input sample |
| in_q | input | 12 | Signed Q input sample |
| out_i | output | 12 | Signed I output, one per clock |
| out_q | output | 12 | Signed Q output, one per clock |

## Verification
The bench feeds isolated impulses and compares every output cycle against a convolution model. This model exposes a wrong pipeline latency, a wrong stuffing phase or a wrong comb delay, because each of these shifts or distorts the impulse shape. Constant inputs near full scale at both rates catch a wrong scaling constant, a missing rounding offset or an accumulator that is too narrow. Any of these shows up as a DC level off by one or a wrapped sign. Three further tests each target one fault:
- Slots are deliberately left empty while junk data is strobed between slots. A design that latched off-slot data, or kept stale samples in empty slots, would show the injected values at the output.
- A rate switch in mid-stream must zero the outputs at once and restart the slot phase. A design that kept old integrator contents would leak a decaying tail.
- Opposite signals on I and Q catch any crossing between the two channels.

// File: rtl/cic_pkg.sv
// Shared types and helpers for the selectable-rate CIC interpolator.
// Assumes only the two factors 3 and 4 are ever requested.
package cic_pkg;

    typedef enum logic {
        RATE_3 = 1'b0,
        RATE_4 = 1'b1
    } rate_e;

    localparam int RATE_LO = 3;
    localparam int RATE_HI = 4;

    // Upsampling factor for a rate code.
    function automatic int rate_factor(rate_e r);
        return (r == RATE_4) ? RATE_HI : RATE_LO;
    endfunction

    // Rounded 2^shift / R^(stages-1): the gain-normalising multiplier.
    function automatic int norm_gain(rate_e r, int stages, int shift);
        int g;
        g = 1;
        for (int s = 0; s < stages - 1; s++) g = g * rate_factor(r);
        return ((1 << shift) + g / 2) / g;
    endfunction

endpackage

// File: rtl/cic_comb_chain.sv
// Comb section for one channel: N first-difference stages that advance only
// on input-slot ticks, followed by a zero-stuffing output register.
// Assumes din is already sign-extended to the accumulator width.
module cic_comb_chain #(
    parameter int W = 16,
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [N-1:0][W-1:0] dly;
    logic [W-1:0]        stg [N+1];

    // Chain of differences between the current value and the stored one.
    always_comb begin
        stg[0] = din;
        for (int j = 0; j < N; j++) stg[j+1] = stg[j] - dly[j];
    end

    // Store each stage input on a slot tick, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dly <= '0;
        end else if (tick) begin
            for (int j = 0; j < N; j++) dly[j] <= stg[j];
        end
    end

    // Zero-stuffing: emit the comb result on a tick cycle, zero elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) dout <= '0;
        else               dout <= tick ? stg[N] : '0;
    end

    // R7: comb state must not move on non-slot cycles.
    p_comb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(dly));

endmodule

// File: rtl/cic_integ_chain.sv
// Integrator section for one channel: N running sums at the high rate.
// Assumes wraparound arithmetic; the final sum fits W bits by sizing.
module cic_integ_chain #(
    parameter int W = 16,
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [N-1:0][W-1:0] acc;

    // Each stage accumulates the previous stage's registered value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else begin
            for (int j = 0; j < N; j++) begin
                if (j == 0) acc[j] <= acc[j] + din;
                else        acc[j] <= acc[j] + acc[j-1];
            end
        end
    end

    assign dout = acc[N-1];

    // R8: a clear request empties every integrator on the next cycle.
    p_integ_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));

endmodule

// File: rtl/cic_gain_norm.sv
// Gain normalisation for one channel: multiply by a rate-dependent constant,
// add half an LSB, arithmetic shift and truncate to the output width.
// Assumes the normalised value fits W_OUT bits for in-range inputs.
module cic_gain_norm
    import cic_pkg::*;
#(
    parameter int W_ACC = 16,
    parameter int W_OUT = 12,
    parameter int N     = 3,
    parameter int SHIFT = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  rate_e                   rate,
    input  logic        [W_ACC-1:0] acc,
    output logic signed [W_OUT-1:0] dout
);

    localparam int KW = SHIFT + 2;
    localparam int MW = W_ACC + KW;

    logic signed [KW-1:0] kmul;
    logic signed [MW-1:0] prod;
    logic signed [MW-1:0] rnd;

    // Select the multiplier for the active rate and form the rounded product.
    always_comb begin
        kmul = (rate == RATE_4) ? KW'(norm_gain(RATE_4, N, SHIFT))
                                : KW'(norm_gain(RATE_3, N, SHIFT));
        prod = MW'($signed(acc)) * MW'(kmul);
        rnd  = prod + (MW'(1) <<< (SHIFT - 1));
    end

    // Register the shifted result.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) dout <= '0;
        else               dout <= W_OUT'(rnd >>> SHIFT);
    end

endmodule

// File: rtl/cic_interp_iq.sv
// Dual-channel CIC interpolator, factor 3 or 4 chosen at run time.
// Owns the slot phase counter and the rate register, and drives one
// comb / integrator / normaliser lane per channel.
// Assumes one input sample per slot; a rate change flushes all state.
module cic_interp_iq
    import cic_pkg::*;
#(
    parameter int W_IN       = 12,
    parameter int STAGES     = 3,
    parameter int NORM_SHIFT = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rate_sel,
    input  logic                   in_valid,
    input  logic signed [W_IN-1:0] in_i,
    input  logic signed [W_IN-1:0] in_q,
    output logic signed [W_IN-1:0] out_i,
    output logic signed [W_IN-1:0] out_q
);

    localparam int R_MAX  = RATE_HI;
    localparam int GROWTH = (STAGES - 1) * $clog2(R_MAX);
    localparam int W_ACC  = W_IN + GROWTH;
    localparam int PH_W   = $clog2(R_MAX);
    localparam int N_CH   = 2;

    rate_e             rate_q;
    logic [PH_W-1:0]   phase;
    logic [PH_W-1:0]   phase_last;
    logic              rate_chg;
    logic              tick;

    logic signed [W_IN-1:0] ch_in  [N_CH];
    logic signed [W_IN-1:0] ch_out [N_CH];

    assign rate_chg   = (rate_e'(rate_sel) != rate_q);
    assign tick       = (phase == '0) && !rate_chg;
    assign phase_last = PH_W'(rate_factor(rate_q) - 1);

    // Track the active rate and step the slot phase, restarting on a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= rate_e'(rate_sel);
            phase  <= '0;
        end else if (rate_chg) begin
            rate_q <= rate_e'(rate_sel);
            phase  <= '0;
        end else begin
            phase  <= (phase == phase_last) ? '0 : phase + 1'b1;
        end
    end

    assign ch_in[0] = in_i;
    assign ch_in[1] = in_q;

    for (genvar c = 0; c < N_CH; c++) begin : g_lane
        logic [W_ACC-1:0] smp;
        logic [W_ACC-1:0] stuffed;
        logic [W_ACC-1:0] sum;

        // Missing sample in a slot enters as zero.
        assign smp = in_valid ? W_ACC'(ch_in[c]) : '0;

        cic_comb_chain #(.W(W_ACC), .N(STAGES)) u_comb (
            .clk(clk), .rst_n(rst_n), .clr(rate_chg), .tick(tick),
            .din(smp), .dout(stuffed));

        cic_integ_chain #(.W(W_ACC), .N(STAGES)) u_integ (
            .clk(clk), .rst_n(rst_n), .clr(rate_chg),
            .din(stuffed), .dout(sum));

        cic_gain_norm #(.W_ACC(W_ACC), .W_OUT(W_IN), .N(STAGES),
                        .SHIFT(NORM_SHIFT)) u_norm (
            .clk(clk), .rst_n(rst_n), .clr(rate_chg), .rate(rate_q),
            .acc(sum), .dout(ch_out[c]));
    end

    assign out_i = ch_out[0];
    assign out_q = ch_out[1];

    // R1: reset drives both outputs to zero.
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (out_i == '0 && out_q == '0));

    // R8: a rate change zeroes both outputs on the following cycle.
    p_rate_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rate_chg |=> (out_i == '0 && out_q == '0));

    // R2: slots are never on adjacent cycles.
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R2: after a change the very next cycle is a slot.
    p_restart_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rate_chg |=> (phase == '0));

endmodule

// File: tb/tb_cic_interp_iq.sv
`timescale 1ns/1ps
module tb_cic_interp_iq;

    localparam int W = 12;
    localparam int HIST = 4096;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                rate_sel = 1'b1;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_i = '0;
    logic signed [W-1:0] in_q = '0;
    logic signed [W-1:0] out_i;
    logic signed [W-1:0] out_q;

    int checks = 0;
    int errors = 0;
    int e      = 0;
    int rate   = 4;
    int vi [HIST];
    int vq [HIST];
    int lfsr   = 32'h1ACE;
    string cur_req = "R1";

    cic_interp_iq dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .out_i(out_i), .out_q(out_q));

    always #4 clk = ~clk;

    // Count of ways three values in [0,R-1] sum to k (window self-convolution).
    function automatic longint hcoef(int k, int r);
        longint n = 0;
        for (int a = 0; a < r; a++)
            for (int b = 0; b < r; b++)
                if (k - a - b >= 0 && k - a - b < r) n++;
        return n;
    endfunction

    function automatic int norm(longint acc, int r);
        longint k = (r == 4) ? 256 : 455;
        longint p = acc * k + 2048;
        return int'(p >>> 12);
    endfunction

    function automatic int expect_ch(bit q);
        longint acc = 0;
        for (int k = 0; k <= 3 * rate - 3; k++) begin
            int idx = e - 4 - k;
            if (idx >= 1 && idx < HIST) acc += hcoef(k, rate) * (q ? vq[idx] : vi[idx]);
        end
        return norm(acc, rate);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, e);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < HIST; i++) begin vi[i] = 0; vq[i] = 0; end
        e = 0;
    endtask

    // One clock: drive, capture in the model, compare at the falling edge.
    task automatic step(bit v, int di, int dq);
        in_valid = v; in_i = W'(di); in_q = W'(dq);
        @(posedge clk);
        e++;
        if (e < HIST && (e - 1) % rate == 0 && v) begin vi[e] = di; vq[e] = dq; end
        @(negedge clk);
        check(cur_req, int'(out_i), expect_ch(1'b0));
        check(cur_req, int'(out_q), expect_ch(1'b1));
    endtask

    // One slot with a sample, then idle edges up to the next slot.
    task automatic feed(int di, int dq);
        step(1'b1, di, dq);
        for (int i = 1; i < rate; i++) step(1'b0, 0, 0);
    endtask

    task automatic do_reset(bit rs);
        rst_n = 1'b0; in_valid = 1'b0; rate_sel = rs;
        @(posedge clk); @(posedge clk);
        clear_model();
        rate = rs ? 4 : 3;
        @(negedge clk);
        check("R1", int'(out_i), 0);
        check("R1", int'(out_q), 0);
        rst_n = 1'b1;
    endtask

    task automatic set_rate(bit rs);
        rate_sel = rs; in_valid = 1'b1; in_i = 12'sd700; in_q = -12'sd700;
        @(posedge clk);
        clear_model();
        rate = rs ? 4 : 3;
        @(negedge clk);
        check("R8", int'(out_i), 0);
        check("R8", int'(out_q), 0);
    endtask

    function automatic int next_rand();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
        return (lfsr % 4095) - 2047;
    endfunction

    task automatic t_reset_r1();
        cur_req = "R1";
        do_reset(1'b1);
        for (int i = 0; i < 6; i++) step(1'b0, 0, 0);
    endtask

    task automatic t_impulse_r3_r6();
        cur_req = "R3/R6";
        do_reset(1'b1);
        feed(100, -37);
        for (int i = 0; i < 16; i++) step(1'b0, 0, 0);
        do_reset(1'b0);
        feed(0, 500);
        for (int i = 0; i < 12; i++) step(1'b0, 0, 0);
    endtask

    task automatic t_dc_r5(bit rs, int xi, int xq);
        cur_req = "R5";
        do_reset(rs);
        for (int i = 0; i < 10; i++) feed(xi, xq);
        check("R5", int'(out_i), xi);
        check("R5", int'(out_q), xq);
    endtask

    task automatic t_fullscale_r9();
        cur_req = "R9";
        do_reset(1'b1);
        for (int i = 0; i < 10; i++) feed(2047, -2048);
        check("R9", int'(out_i), 2047);
        check("R9", int'(out_q), -2048);
    endtask

    task automatic t_random_r2_r4(bit rs);
        cur_req = rs ? "R2/R4 rate4" : "R2/R4 rate3";
        do_reset(rs);
        for (int i = 0; i < 30; i++) feed(next_rand(), next_rand());
    endtask

    task automatic t_gaps_r7();
        cur_req = "R7";
        do_reset(1'b1);
        feed(800, -800);
        step(1'b0, 1500, -1500);            // empty slot, data must not enter
        step(1'b1, 2000, -2000);            // off-slot strobes, ignored
        step(1'b1, -2000, 2000);
        step(1'b0, 0, 0);
        feed(300, 300);
        for (int i = 0; i < 14; i++) step(1'b0, 0, 0);
    endtask

    task automatic t_switch_r8();
        cur_req = "R8";
        do_reset(1'b1);
        for (int i = 0; i < 5; i++) feed(1200, -900);
        step(1'b0, 0, 0);
        set_rate(1'b0);
        cur_req = "R8 after switch";
        for (int i = 0; i < 8; i++) feed(-400, 650);
        check("R8", int'(out_i), -400);
        check("R8", int'(out_q), 650);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_r1();
        t_impulse_r3_r6();
        t_dc_r5(1'b0, 1000, -1500);
        t_dc_r5(1'b1, 1000, -1500);
        t_dc_r5(1'b0, 2047, -2047);
        t_fullscale_r9();
        t_random_r2_r4(1'b0);
        t_random_r2_r4(1'b1);
        t_gaps_r7();
        t_switch_r8();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule